// File: doc/BRIEF.md
# One-Time-Programmable Fuse Bank Register Controller

This block is the register front end of a one-time-programmable fuse bank of 1024 bytes, which is modelled here as flops inside the block. Software reaches it through word-wide register reads and writes on a simple request port. Through these registers it can select a byte and a bit, fetch a byte of the bank into a data register, or burn a single fuse bit. It can also read a strap word that the block recovers by a bitwise vote over three stored copies.

Burning a fuse takes two command words that must follow each other as command writes. A burn can only set a bit and never clear one. A configuration register holds a disable bit and eight lock bits. Once a lock bit is set it cannot be cleared, and it freezes two other configuration bits. Reads and burns finish in the clock cycle of the command write. Register reset (`rst_n`) returns the registers to their defaults but leaves the fuse contents alone. Only the power-up clear (`pwr_rst_n`) empties the bank.

Top module: `fuse_ctl`

## Requirements
- R1: After register reset, status reads 0x00000001, configuration reads 0x20000000, and address and data read 0.
- R2: The address register (offset 0x04) keeps only the byte index in bits 9:0 and the bit index in bits 12:10. Bits above 12 read 0.
- R3: Writing 0x2 to the command register (offset 0x14) loads the bank byte at the byte index into the data register (offset 0x08), zero-extended. The same write sets status bits 0 and 1.
- R4: Writing 0xBF79E5D0 to the command register burns a fuse only when the previous command-register write was 0x1. Writes to other registers in between do not break this pairing. Any other command value in between cancels it.
- R5: A burn ORs a 1 into the selected bit of the selected byte and sets status bits 0 and 1. Bits that are already 1 stay 1.
- R6: In status (offset 0x00), bit 0 (ready) and bit 1 (read-done) cannot be set by writes. Writing 1 to bit 1 clears read-done. Bit 2 (interrupt enable) takes the written value. All other status bits read 0.
- R7: Writing exactly 0x1 to the data register clears it. Every other write leaves it unchanged.
- R8: In configuration (offset 0x0C), bit 31 and bits 23:16 are set by writing 1 and are never cleared. If bit 16+k is already set before a write, bits k and 8+k keep their old value. All other bits take the written value.
- R9: The strap register (offset 0x10) returns the bitwise two-of-three vote of three little-endian words held in bank bytes 0-3, 4-7 and 8-11. Writes to it are ignored.
- R10: Reads of the command register, of offsets above 0x14, or of addresses that are not word aligned return 0. Writes to offsets above 0x14 or to unaligned addresses change nothing.
- R11: Fuse contents survive register reset and are cleared only by the power-up clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_rst_n | input | 1 | Power-up clear of the fuse bank, active low, asynchronous |
| rst_n | input | 1 | Register reset, active low, asynchronous |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid combinationally while bus_rd is high |

## Verification
The hardest case to reach from the ports is a command pair that is split or spoiled. This covers a foreign command between the two words, a disguised command sent to an unaligned address, and the second word sent without the first. The bench creates each case with its own sequence and reads the target byte back through the read command, which shows whether the burn took place. The strap vote needs a set of fuse bits in which each bit position is held by one, two or three copies. The bench builds that set with single-bit burns in bytes 0 to 11, then issues a register reset to show the burned bits and the strap vote are still there.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  // Register word offsets (byte addresses)
  localparam logic [31:0] OFS_STAT  = 32'h00;
  localparam logic [31:0] OFS_ADDR  = 32'h04;
  localparam logic [31:0] OFS_DATA  = 32'h08;
  localparam logic [31:0] OFS_CFG   = 32'h0C;
  localparam logic [31:0] OFS_STRAP = 32'h10;
  localparam logic [31:0] OFS_CMD   = 32'h14;

  // Command and data magic values
  localparam logic [31:0] CMD_ARM   = 32'h0000_0001;
  localparam logic [31:0] CMD_READ  = 32'h0000_0002;
  localparam logic [31:0] CMD_BURN  = 32'hBF79_E5D0;
  localparam logic [31:0] DATA_CLR  = 32'h0000_0001;

  // Configuration layout
  localparam int CFG_DIS_BIT = 31;
  localparam int CFG_LOCK_LO = 16;
  localparam int CFG_LOCK_N  = 8;
  localparam logic [31:0] CFG_RST = 32'h2000_0000;
  localparam logic [31:0] CFG_STICKY = 32'h80FF_0000;

  // Strap copies
  localparam int STRAP_COPIES = 3;
  localparam int STRAP_BYTES  = 4;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STAT, SEL_ADDR, SEL_DATA, SEL_CFG, SEL_STRAP, SEL_CMD
  } reg_sel_e;
endpackage

// File: rtl/fuse_cfg_lock.sv
module fuse_cfg_lock
  import fuse_pkg::*;
(
  input  logic [31:0] cur,
  input  logic [31:0] wr_val,
  output logic [31:0] nxt
);
  always_comb begin
    nxt = wr_val;
    nxt[CFG_DIS_BIT] = cur[CFG_DIS_BIT] | wr_val[CFG_DIS_BIT];
    for (int k = 0; k < CFG_LOCK_N; k++) begin
      nxt[CFG_LOCK_LO + k] = cur[CFG_LOCK_LO + k] | wr_val[CFG_LOCK_LO + k];
      if (cur[CFG_LOCK_LO + k]) begin
        nxt[k]              = cur[k];
        nxt[CFG_LOCK_N + k] = cur[CFG_LOCK_N + k];
      end
    end
  end
endmodule

// File: rtl/fuse_strap_vote.sv
module fuse_strap_vote #(
  parameter int W = 32
) (
  input  logic [3*W-1:0] copies,
  output logic [W-1:0]   vote
);
  logic [W-1:0] c0, c1, c2;
  assign c0 = copies[W-1:0];
  assign c1 = copies[2*W-1:W];
  assign c2 = copies[3*W-1:2*W];
  assign vote = (c0 & c1) | (c0 & c2) | (c1 & c2);
endmodule

// File: rtl/fuse_store.sv
module fuse_store #(
  parameter int BYTES     = 1024,
  parameter int TAP_BYTES = 12,
  localparam int IDX_W    = $clog2(BYTES)
) (
  input  logic                   clk,
  input  logic                   pwr_rst_n,
  input  logic                   burn_en,
  input  logic [IDX_W-1:0]       idx,
  input  logic [2:0]             bitpos,
  output logic [7:0]             rd_byte,
  output logic [8*TAP_BYTES-1:0] tap
);
  logic [7:0] cells [BYTES];

  for (genvar g = 0; g < BYTES; g++) begin : g_cell
    logic       hit;
    logic [7:0] cell_q, cell_d;
    assign hit = burn_en && (idx == IDX_W'(g));
    always_comb begin
      cell_d = cell_q;
      if (hit) cell_d = cell_q | (8'h01 << bitpos);
    end
    always_ff @(posedge clk or negedge pwr_rst_n) begin
      if (!pwr_rst_n)  cell_q <= '0;
      else if (hit)    cell_q <= cell_d;
    end
    assign cells[g] = cell_q;
  end

  for (genvar t = 0; t < TAP_BYTES; t++) begin : g_tap
    assign tap[8*t +: 8] = cells[t];
  end

  assign rd_byte = cells[idx];

  // R5: a cell under a fixed index never loses a set bit
  a_r5_no_clear: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (idx == $past(idx)) |-> ((~rd_byte & $past(rd_byte)) == 8'h00));
endmodule

// File: rtl/fuse_ctl.sv
module fuse_ctl
  import fuse_pkg::*;
#(
  parameter int ARRAY_BYTES = 1024,
  parameter int BUS_AW      = 12,
  localparam int IDX_W      = $clog2(ARRAY_BYTES),
  localparam int ADDR_W     = IDX_W + 3,
  localparam int TAP_BYTES  = STRAP_COPIES * STRAP_BYTES
) (
  input  logic              clk,
  input  logic              pwr_rst_n,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  reg_sel_e sel;
  logic ie_q, ie_d, rdone_q, rdone_d, rdy_q, rdy_d, armed_q, armed_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]  data_q, data_d, arr_byte;
  logic [31:0] cfg_q, cfg_d, cfg_nxt, strap_word;
  logic [8*TAP_BYTES-1:0] tap;
  logic burn_en;

  // Address decode
  always_comb begin
    sel = SEL_NONE;
    if (bus_addr[1:0] == 2'b00) begin
      case (32'(bus_addr))
        OFS_STAT:  sel = SEL_STAT;
        OFS_ADDR:  sel = SEL_ADDR;
        OFS_DATA:  sel = SEL_DATA;
        OFS_CFG:   sel = SEL_CFG;
        OFS_STRAP: sel = SEL_STRAP;
        OFS_CMD:   sel = SEL_CMD;
        default:   sel = SEL_NONE;
      endcase
    end
  end

  fuse_cfg_lock u_cfg (.cur(cfg_q), .wr_val(bus_wdata), .nxt(cfg_nxt));

  fuse_store #(.BYTES(ARRAY_BYTES), .TAP_BYTES(TAP_BYTES)) u_store (
    .clk(clk), .pwr_rst_n(pwr_rst_n), .burn_en(burn_en),
    .idx(addr_q[IDX_W-1:0]), .bitpos(addr_q[ADDR_W-1:IDX_W]),
    .rd_byte(arr_byte), .tap(tap));

  fuse_strap_vote #(.W(8*STRAP_BYTES)) u_vote (.copies(tap), .vote(strap_word));

  // Next-state logic
  always_comb begin
    ie_d = ie_q; rdone_d = rdone_q; rdy_d = rdy_q; armed_d = armed_q;
    addr_d = addr_q; data_d = data_q; cfg_d = cfg_q; burn_en = 1'b0;
    if (bus_wr) begin
      case (sel)
        SEL_STAT: begin
          ie_d = bus_wdata[2];
          if (bus_wdata[1]) rdone_d = 1'b0;
        end
        SEL_ADDR: addr_d = bus_wdata[ADDR_W-1:0];
        SEL_DATA: if (bus_wdata == DATA_CLR) data_d = '0;
        SEL_CFG:  cfg_d = cfg_nxt;
        SEL_CMD: begin
          armed_d = (bus_wdata == CMD_ARM);
          if (bus_wdata == CMD_READ) begin
            data_d = arr_byte; rdy_d = 1'b1; rdone_d = 1'b1;
          end else if (bus_wdata == CMD_BURN && armed_q) begin
            burn_en = 1'b1; rdy_d = 1'b1; rdone_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= 1'b0; rdone_q <= 1'b0; rdy_q <= 1'b1; armed_q <= 1'b0;
      addr_q <= '0; data_q <= '0; cfg_q <= CFG_RST;
    end else if (bus_wr) begin
      ie_q <= ie_d; rdone_q <= rdone_d; rdy_q <= rdy_d; armed_q <= armed_d;
      addr_q <= addr_d; data_q <= data_d; cfg_q <= cfg_d;
    end
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (sel)
        SEL_STAT:  bus_rdata = {29'b0, ie_q, rdone_q, rdy_q};
        SEL_ADDR:  bus_rdata = 32'(addr_q);
        SEL_DATA:  bus_rdata = {24'b0, data_q};
        SEL_CFG:   bus_rdata = cfg_q;
        SEL_STRAP: bus_rdata = strap_word;
        default:   bus_rdata = '0;
      endcase
    end
  end

  // R4: any command other than the arming word disarms
  a_r4_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == SEL_CMD && bus_wdata != CMD_ARM) |=> !armed_q);
  // R3: read command loads the byte and raises read-done
  a_r3_read_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == SEL_CMD && bus_wdata == CMD_READ)
      |=> (rdone_q && data_q == $past(arr_byte)));
  // R7: non-clear writes leave data untouched
  a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == SEL_DATA && bus_wdata != DATA_CLR) |=> $stable(data_q));
  // R8: sticky bits never drop
  a_r8_sticky_kept: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cfg_q & $past(cfg_q) & CFG_STICKY) == ($past(cfg_q) & CFG_STICKY)));
  // R8: bits guarded by a lock set beforehand do not move
  a_r8_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((cfg_q ^ $past(cfg_q)) &
               {16'h0, $past(cfg_q[23:16]), $past(cfg_q[23:16])}) == 32'h0));
  // R10: writes to unmapped or unaligned addresses change nothing
  a_r10_bad_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == SEL_NONE) |=> ($stable(addr_q) && $stable(data_q) &&
      $stable(cfg_q) && $stable(rdone_q) && $stable(ie_q) && $stable(armed_q)));
endmodule

// File: tb/fuse_ctl_bench.sv
module fuse_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BURN = 32'hBF79_E5D0;

  logic clk = 1'b0, pwr_rst_n, rst_n, bus_wr, bus_rd;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  int n_tests = 0, n_fail = 0;

  fuse_ctl u_fuse_ctl (.clk(clk), .pwr_rst_n(pwr_rst_n), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic burn(input int byt, input int bt);
    wr(12'h004, 32'((bt << 10) | byt));
    wr(12'h014, 32'h1);
    wr(12'h014, BURN);
  endtask

  task automatic fetch(input int byt, output logic [31:0] d);
    wr(12'h004, 32'(byt));
    wr(12'h014, 32'h2);
    rd(12'h008, d);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(12'h000, v); chk("R1 status", v, 32'h1);
    rd(12'h00C, v); chk("R1 config", v, 32'h2000_0000);
    rd(12'h004, v); chk("R1 address", v, 32'h0);
    rd(12'h008, v); chk("R1 data", v, 32'h0);
  endtask

  task automatic t_addr;
    logic [31:0] v;
    wr(12'h004, 32'hFFFF_FFFF); rd(12'h004, v); chk("R2 addr mask", v, 32'h1FFF);
  endtask

  task automatic t_burn_read;
    logic [31:0] v;
    wr(12'h000, 32'h2);
    burn(1023, 7);
    rd(12'h000, v); chk("R5 flags after burn", v, 32'h3);
    wr(12'h000, 32'h2);
    fetch(1023, v); chk("R3 read top byte", v, 32'h80);
    rd(12'h000, v); chk("R3 flags after read", v, 32'h3);
    burn(1023, 0); burn(1023, 7);
    fetch(1023, v); chk("R5 OR keeps bits", v, 32'h81);
  endtask

  task automatic t_guard;
    logic [31:0] v;
    wr(12'h004, 32'h100);
    wr(12'h014, 32'h1); wr(12'h014, 32'h55); wr(12'h014, BURN);
    fetch(256, v); chk("R4 foreign cmd cancels", v, 32'h0);
    wr(12'h004, 32'h100); wr(12'h014, BURN);
    fetch(256, v); chk("R4 unarmed burn", v, 32'h0);
    wr(12'h004, 32'h100); wr(12'h014, 32'h1); wr(12'h015, 32'h2); wr(12'h014, BURN);
    fetch(256, v); chk("R4 unaligned write no disarm", v, 32'h1);
    wr(12'h004, 32'h0900); wr(12'h014, 32'h1); wr(12'h008, 32'h7); wr(12'h014, BURN);
    fetch(256, v); chk("R4 pairing across other writes", v, 32'h5);
  endtask

  task automatic t_status;
    logic [31:0] v;
    wr(12'h000, 32'h2); rd(12'h000, v); chk("R6 w1c read-done", v, 32'h1);
    wr(12'h000, 32'hFFFF_FFFD); rd(12'h000, v); chk("R6 ie set, ro bits", v, 32'h5);
    wr(12'h000, 32'h0); rd(12'h000, v); chk("R6 ie clear", v, 32'h1);
  endtask

  task automatic t_data;
    logic [31:0] v;
    fetch(1023, v);
    wr(12'h008, 32'h2); rd(12'h008, v); chk("R7 other write ignored", v, 32'h81);
    wr(12'h008, 32'h0); rd(12'h008, v); chk("R7 zero write ignored", v, 32'h81);
    wr(12'h008, 32'h1); rd(12'h008, v); chk("R7 clear", v, 32'h0);
  endtask

  task automatic t_cfg;
    logic [31:0] v;
    wr(12'h00C, 32'h0000_0101); rd(12'h00C, v); chk("R8 plain write", v, 32'h0000_0101);
    wr(12'h00C, 32'h0001_0000); rd(12'h00C, v); chk("R8 lock same write", v, 32'h0001_0000);
    wr(12'h00C, 32'h0000_0101); rd(12'h00C, v); chk("R8 frozen bits", v, 32'h0001_0000);
    wr(12'h00C, 32'h8000_FFFF); rd(12'h00C, v); chk("R8 disable and free bits", v, 32'h8001_FEFE);
    wr(12'h00C, 32'h0); rd(12'h00C, v); chk("R8 sticky", v, 32'h8001_0000);
  endtask

  task automatic t_strap;
    logic [31:0] v;
    burn(0, 0); burn(0, 1); burn(0, 2); burn(0, 3);
    burn(4, 0); burn(4, 1);
    burn(8, 0); burn(8, 2); burn(9, 0);
    rd(12'h010, v); chk("R9 vote", v, 32'h7);
    wr(12'h010, 32'hFFFF_FFFF); rd(12'h010, v); chk("R9 write ignored", v, 32'h7);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    rd(12'h014, v); chk("R10 command reads 0", v, 32'h0);
    rd(12'h018, v); chk("R10 unmapped reads 0", v, 32'h0);
    rd(12'h001, v); chk("R10 unaligned reads 0", v, 32'h0);
    wr(12'h004, 32'h3FF);
    wr(12'h01C, 32'h5); wr(12'h005, 32'h1);
    rd(12'h004, v); chk("R10 bad writes no effect", v, 32'h3FF);
    wr(12'h009, 32'h1); wr(12'h014, 32'h2); wr(12'h00A, 32'h1);
    rd(12'h008, v); chk("R10 unaligned clear ignored", v, 32'h81);
  endtask

  task automatic t_keep;
    logic [31:0] v;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(12'h00C, v); chk("R11 config back to reset", v, 32'h2000_0000);
    fetch(1023, v); chk("R11 fuses kept", v, 32'h81);
    rd(12'h010, v); chk("R11 strap kept", v, 32'h7);
    @(negedge clk); pwr_rst_n = 1'b0;
    @(negedge clk); pwr_rst_n = 1'b1;
    fetch(1023, v); chk("R11 power-up clear", v, 32'h0);
  endtask

  initial begin
    pwr_rst_n = 1'b0; rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    pwr_rst_n = 1'b1; rst_n = 1'b1;
    t_reset; t_addr; t_burn_read; t_guard; t_status;
    t_data; t_cfg; t_strap; t_unmapped; t_keep;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule